// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block takes two-channel serial audio on three wires (a bit clock, a frame clock and a data line) and turns it into one parallel left sample and one parallel right sample per frame. Samples arrive as two's complement with the most significant bit first, and the left word always comes before the right word within a frame. Four framings are supported: right-justified, I2S, left-justified and a DSP style, where a short frame-clock pulse marks the start of each word. In right-justified framing the word length can be set to 24, 20 or 16 bits. Each channel also has a flag that reports a long run of silent samples.

The capture logic runs on the serial bit clock. Finished sample pairs cross into the system clock through a toggle handshake and leave on a valid/ready stream port. The silence flags pass through a plain two-stage synchronizer. The framing is chosen by two mode pins ORed with two configuration bits, so a board can strap the pins and software can leave its bits at zero, or the reverse.

Output stream rules. `out_valid` rises when a new pair is loaded. While `out_valid` is high and `out_ready` is low, the pair is held unchanged. A pair completed in the receive domain while the output slot is still full is discarded, and the held pair is kept. When `out_ready` is held high, each pair appears as a single-cycle `out_valid` pulse.

Top module: `aud_serial_rx`

## Requirements
- R1: The effective framing is `mode_pin | cfg_mode`, encoded as 00 = right-justified, 01 = I2S, 10 = left-justified and 11 = DSP.
- R2: Left-justified framing treats a high frame clock as the left channel. The MSB is the bit sampled on the first rising bit-clock edge that sees the new frame-clock level.
- R3: I2S framing treats a low frame clock as the left channel. The MSB is sampled one rising bit-clock edge after the first edge that sees the new level.
- R4: DSP framing samples data and frame clock on the falling bit-clock edge. The first bit sampled low after a high frame-clock pulse is the MSB. The first pulse after reset starts the left word, and later pulses alternate right, left, and so on.
- R5: Right-justified framing numbers the bits of each half-frame from 0, where bit 0 is the first rising edge that sees the new level. Capture starts at bit 8, 12 or 16 and ends after bit 31. The start is set by `cfg_wlen` = 00 (24 bits, also used for 11), 01 (20 bits) or 10 (16 bits).
- R6: Every word is left-aligned into the 24-bit output, with zeros in the unused low bits. In the framings other than right-justified, bits after the 24th are dropped.
- R7: Capture begins at the first frame boundary seen after reset. A pair is emitted when a right word completes after a captured left word, which happens at the next frame boundary.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_left` and `out_right` hold. A pair completed during that time is discarded.
- R9: A channel's zero flag goes high once more than `ZERO_FRAMES` consecutive words of that channel were all zeros. It falls after the next non-zero word.
- R10: After reset, `out_valid`, `zero_left` and `zero_right` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bclk | input | 1 | Serial bit clock |
| lrck | input | 1 | Serial frame clock |
| sdata | input | 1 | Serial audio data |
| mode_pin | input | 2 | Framing select from pins |
| cfg_mode | input | 2 | Framing select from configuration, ORed with the pins |
| cfg_wlen | input | 2 | Right-justified word length select |
| out_valid | output | 1 | Sample pair available |
| out_ready | input | 1 | Consumer accepts the pair |
| out_left | output | SAMPLE_W | Left sample, left-aligned |
| out_right | output | SAMPLE_W | Right sample, left-aligned |
| zero_left | output | 1 | Left channel long-silence flag |
| zero_right | output | 1 | Right channel long-silence flag |

## Verification
On every cycle, the assertions check the stream hold rule, and that each silence flag rises only right after a zero word on its own channel and falls right after a non-zero one. They also check that 16-bit right-justified words always carry zeros in their low byte. Only the bench's scenarios can show the rest: correct bit placement and channel order in each framing, the ORing of mode sources, truncation of long words, the first-boundary start-up and discarding under back-pressure. They also show the exact frame count at which a silence flag switches.

// File: rtl/aud_rx_pkg.sv
`timescale 1ns/1ps
package aud_rx_pkg;
  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_LJ  = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;
endpackage

// File: rtl/aud_rx_deser.sv
`timescale 1ns/1ps
// Bit-clock domain: frame boundary detection, bit windowing, word assembly.
module aud_rx_deser
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int RJ_SLOT  = 32,
  parameter int CNT_W    = 6
) (
  input  logic                bclk,
  input  logic                rst_n,
  input  logic                sdata,
  input  logic                lrck,
  input  fmt_e                fmt,
  input  logic [1:0]          wlen_sel,
  output logic [SAMPLE_W-1:0] pair_l,
  output logic [SAMPLE_W-1:0] pair_r,
  output logic                pair_tgl,
  output logic                cmt_v,
  output logic                cmt_side,
  output logic [SAMPLE_W-1:0] cmt_word
);
  localparam int NB_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] IDX_MAX = '1;
  localparam logic [CNT_W-1:0] SLOT_C  = CNT_W'(RJ_SLOT);
  localparam logic [NB_W-1:0]  TOP_C   = NB_W'(SAMPLE_W - 1);
  localparam logic [NB_W-1:0]  FULL_C  = NB_W'(SAMPLE_W);

  // falling-edge capture used by the pulse-sync framing
  logic ds_d, ds_f;
  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      ds_d <= 1'b0;
      ds_f <= 1'b0;
    end else begin
      ds_d <= sdata;
      ds_f <= lrck;
    end
  end

  logic                primed, started, f_prev, side, have_left;
  logic [CNT_W-1:0]    idx;
  logic [NB_W-1:0]     nb;
  logic [SAMPLE_W-1:0] acc, left_hold;

  logic                is_dsp, sd, sf, edge_hit, side_new, in_win, take;
  logic [CNT_W-1:0]    wlen, rj_start, bit_idx;
  logic [NB_W-1:0]     nb_base, nb_nxt;
  logic [SAMPLE_W-1:0] acc_base, acc_nxt;

  always_comb begin
    case (wlen_sel)
      2'b01:   wlen = CNT_W'(SAMPLE_W - 4);
      2'b10:   wlen = CNT_W'(SAMPLE_W - 8);
      default: wlen = CNT_W'(SAMPLE_W);
    endcase
    rj_start = SLOT_C - wlen;
  end

  always_comb begin
    is_dsp   = (fmt == FMT_DSP);
    sd       = is_dsp ? ds_d : sdata;
    sf       = is_dsp ? ds_f : lrck;
    edge_hit = primed && (is_dsp ? (f_prev && !sf) : (f_prev != sf));
    if (is_dsp)               side_new = started ? !side : 1'b0;
    else if (fmt == FMT_I2S)  side_new = sf;
    else                      side_new = !sf;
    if (edge_hit)             bit_idx = '0;
    else if (idx == IDX_MAX)  bit_idx = idx;
    else                      bit_idx = idx + 1'b1;
    case (fmt)
      FMT_RJ:  in_win = (bit_idx >= rj_start) && (bit_idx < SLOT_C);
      FMT_I2S: in_win = (bit_idx != '0);
      default: in_win = 1'b1;
    endcase
    acc_base = edge_hit ? '0 : acc;
    nb_base  = edge_hit ? '0 : nb;
    take     = (started || edge_hit) && in_win && (nb_base < FULL_C);
    acc_nxt  = acc_base;
    nb_nxt   = nb_base;
    if (take) begin
      acc_nxt = acc_base | ({{(SAMPLE_W-1){1'b0}}, sd} << (TOP_C - nb_base));
      nb_nxt  = nb_base + 1'b1;
    end
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      primed    <= 1'b0;
      started   <= 1'b0;
      f_prev    <= 1'b0;
      side      <= 1'b0;
      have_left <= 1'b0;
      idx       <= '0;
      nb        <= '0;
      acc       <= '0;
      left_hold <= '0;
      pair_l    <= '0;
      pair_r    <= '0;
      pair_tgl  <= 1'b0;
      cmt_v     <= 1'b0;
      cmt_side  <= 1'b0;
      cmt_word  <= '0;
    end else begin
      f_prev <= sf;
      cmt_v  <= 1'b0;
      if (!primed) begin
        primed <= 1'b1;
      end else begin
        idx <= bit_idx;
        acc <= acc_nxt;
        nb  <= nb_nxt;
        if (edge_hit) begin
          started <= 1'b1;
          side    <= side_new;
          if (started) begin
            cmt_v    <= 1'b1;
            cmt_side <= side;
            cmt_word <= acc;
            if (!side) begin
              left_hold <= acc;
              have_left <= 1'b1;
            end else if (have_left) begin
              pair_l    <= left_hold;
              pair_r    <= acc;
              pair_tgl  <= !pair_tgl;
              have_left <= 1'b0;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/aud_rx_zdet.sv
`timescale 1ns/1ps
// Counts consecutive all-zero words of one channel.
module aud_rx_zdet #(
  parameter int SAMPLE_W    = 24,
  parameter int ZERO_FRAMES = 1024,
  parameter bit SIDE        = 1'b0
) (
  input  logic                bclk,
  input  logic                rst_n,
  input  logic                cmt_v,
  input  logic                cmt_side,
  input  logic [SAMPLE_W-1:0] cmt_word,
  output logic                flag
);
  localparam int ZC_W = $clog2(ZERO_FRAMES + 2);
  localparam logic [ZC_W-1:0] LIM = ZC_W'(ZERO_FRAMES + 1);

  logic [ZC_W-1:0] cnt, cnt_n;

  always_comb cnt_n = (cnt == LIM) ? cnt : cnt + 1'b1;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (cmt_v && (cmt_side == SIDE)) begin
      if (cmt_word == '0) begin
        cnt  <= cnt_n;
        flag <= (cnt_n == LIM);
      end else begin
        cnt  <= '0;
        flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/aud_rx_xfer.sv
`timescale 1ns/1ps
// System-clock side: toggle synchronizer, valid/ready output slot, flag sync.
module aud_rx_xfer #(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] pair_l,
  input  logic [SAMPLE_W-1:0] pair_r,
  input  logic                pair_tgl,
  input  logic [1:0]          zf_in,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  output logic [1:0]          zf_out
);
  logic [SYNC_STAGES:0] tsync;
  logic                 fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tsync <= '0;
    else        tsync <= {tsync[SYNC_STAGES-1:0], pair_tgl};
  end

  assign fresh = tsync[SYNC_STAGES] ^ tsync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (fresh && (!out_valid || out_ready)) begin
      out_valid <= 1'b1;
      out_left  <= pair_l;
      out_right <= pair_r;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_fsync
    logic [SYNC_STAGES-1:0] zs;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) zs <= '0;
      else        zs <= {zs[SYNC_STAGES-2:0], zf_in[ch]};
    end
    assign zf_out[ch] = zs[SYNC_STAGES-1];
  end
endmodule

// File: rtl/aud_serial_rx.sv
`timescale 1ns/1ps
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int RJ_SLOT     = 32,
  parameter int CNT_W       = 6,
  parameter int ZERO_FRAMES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                lrck,
  input  logic                sdata,
  input  logic [1:0]          mode_pin,
  input  logic [1:0]          cfg_mode,
  input  logic [1:0]          cfg_wlen,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  output logic                zero_left,
  output logic                zero_right
);
  fmt_e                fmt;
  logic [SAMPLE_W-1:0] pair_l, pair_r, cmt_word;
  logic                pair_tgl, cmt_v, cmt_side;
  logic [1:0]          zf_b, zf_s;

  assign fmt = fmt_e'(mode_pin | cfg_mode);

  aud_rx_deser #(
    .SAMPLE_W(SAMPLE_W), .RJ_SLOT(RJ_SLOT), .CNT_W(CNT_W)
  ) u_deser (
    .bclk(bclk), .rst_n(rst_n), .sdata(sdata), .lrck(lrck),
    .fmt(fmt), .wlen_sel(cfg_wlen),
    .pair_l(pair_l), .pair_r(pair_r), .pair_tgl(pair_tgl),
    .cmt_v(cmt_v), .cmt_side(cmt_side), .cmt_word(cmt_word)
  );

  for (genvar ch = 0; ch < 2; ch++) begin : g_zdet
    aud_rx_zdet #(
      .SAMPLE_W(SAMPLE_W), .ZERO_FRAMES(ZERO_FRAMES), .SIDE(ch == 1)
    ) u_zdet (
      .bclk(bclk), .rst_n(rst_n), .cmt_v(cmt_v), .cmt_side(cmt_side),
      .cmt_word(cmt_word), .flag(zf_b[ch])
    );
  end

  aud_rx_xfer #(
    .SAMPLE_W(SAMPLE_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_xfer (
    .clk(clk), .rst_n(rst_n), .pair_l(pair_l), .pair_r(pair_r),
    .pair_tgl(pair_tgl), .zf_in(zf_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_left(out_left), .out_right(out_right),
    .zf_out(zf_s)
  );

  assign zero_left  = zf_s[0];
  assign zero_right = zf_s[1];
endmodule

// File: rtl/aud_serial_rx_chk.sv
`timescale 1ns/1ps
module aud_serial_rx_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                bclk,
  input logic                rst_n,
  input logic                out_valid,
  input logic                out_ready,
  input logic [SAMPLE_W-1:0] out_left,
  input logic [SAMPLE_W-1:0] out_right,
  input logic [1:0]          mode_pin,
  input logic [1:0]          cfg_mode,
  input logic [1:0]          cfg_wlen,
  input logic                cmt_v,
  input logic                cmt_side,
  input logic [SAMPLE_W-1:0] cmt_word,
  input logic [1:0]          zf_b
);
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)));

  p_rj16_fill_r5: assert property (@(posedge bclk) disable iff (!rst_n)
    (cmt_v && ((mode_pin | cfg_mode) == 2'b00) && (cfg_wlen == 2'b10)) |-> (cmt_word[7:0] == 8'h00));

  p_zl_rise_r9: assert property (@(posedge bclk) disable iff (!rst_n)
    $rose(zf_b[0]) |-> $past(cmt_v && !cmt_side && (cmt_word == '0)));

  p_zr_rise_r9: assert property (@(posedge bclk) disable iff (!rst_n)
    $rose(zf_b[1]) |-> $past(cmt_v && cmt_side && (cmt_word == '0)));

  p_zl_clear_r9: assert property (@(posedge bclk) disable iff (!rst_n)
    (cmt_v && !cmt_side && (cmt_word != '0)) |=> !zf_b[0]);

  p_zr_clear_r9: assert property (@(posedge bclk) disable iff (!rst_n)
    (cmt_v && cmt_side && (cmt_word != '0)) |=> !zf_b[1]);
endmodule

bind aud_serial_rx aud_serial_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .bclk(bclk), .rst_n(rst_n), .out_valid(out_valid),
  .out_ready(out_ready), .out_left(out_left), .out_right(out_right),
  .mode_pin(mode_pin), .cfg_mode(cfg_mode), .cfg_wlen(cfg_wlen),
  .cmt_v(cmt_v), .cmt_side(cmt_side), .cmt_word(cmt_word), .zf_b(zf_b)
);

// File: tb/sim_aud_serial_rx.sv
`timescale 1ns/1ps
module sim_aud_serial_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, lrck = 1'b0, sdata = 1'b0;
  logic [1:0]  mode_pin = 2'b00, cfg_mode = 2'b00, cfg_wlen = 2'b00;
  logic        out_ready = 1'b1;
  logic        out_valid, zero_left, zero_right;
  logic [23:0] out_left, out_right;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R7";
  logic [31:0] exp_l [0:127];
  logic [31:0] exp_r [0:127];
  int exp_wr = 0, exp_rd = 0;

  always #10 clk = ~clk;

  aud_serial_rx #(.ZERO_FRAMES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrck(lrck), .sdata(sdata),
    .mode_pin(mode_pin), .cfg_mode(cfg_mode), .cfg_wlen(cfg_wlen),
    .out_valid(out_valid), .out_ready(out_ready), .out_left(out_left),
    .out_right(out_right), .zero_left(zero_left), .zero_right(zero_right)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] msk(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  // left-align n bits into 24, dropping bits beyond the 24th
  function automatic logic [31:0] exp_word(input logic [31:0] w, input int n);
    logic [31:0] t;
    t = w << (32 - n);
    return {8'h00, t[31:8]};
  endfunction

  task automatic push(input logic [31:0] l, input logic [31:0] r);
    exp_l[exp_wr] = l;
    exp_r[exp_wr] = r;
    exp_wr++;
  endtask

  // consumer: compare every accepted pair against the expected list
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_rd < exp_wr) begin
        chk({cur_req, " left word"}, {8'h00, out_left}, exp_l[exp_rd]);
        chk({cur_req, " right word"}, {8'h00, out_right}, exp_r[exp_rd]);
      end else begin
        chk({cur_req, " R7 unexpected pair"}, 32'd1, 32'd0);
      end
      exp_rd++;
    end
  end

  task automatic drive_bit(input logic d, input logic f, input bit dsp);
    sdata = d;
    lrck  = f;
    #1;
    if (!dsp) begin bclk = 1'b0; #39; bclk = 1'b1; #40; end
    else      begin bclk = 1'b1; #39; bclk = 1'b0; #40; end
  endtask

  // fm: 0 right-justified, 1 I2S, 2 left-justified, 3 DSP
  task automatic send_half(input int fm, input logic [31:0] w, input int nb, input bit right);
    for (int i = 0; i < 32; i++) begin
      logic d, f;
      d = 1'b0;
      case (fm)
        0: begin f = !right; if (i >= 32 - nb) d = w[nb - 1 - (i - (32 - nb))]; end
        1: begin f = right;  if (i >= 1 && i <= nb) d = w[nb - i]; end
        2: begin f = !right; if (i < nb) d = w[nb - 1 - i]; end
        default: begin f = (i == 0); if (i >= 1 && i <= nb) d = w[nb - i]; end
      endcase
      drive_bit(d, f, fm == 3);
    end
  endtask

  task automatic do_reset(input logic [1:0] pin, input logic [1:0] cfg, input logic [1:0] wl);
    rst_n = 1'b0;
    bclk = 1'b0; lrck = 1'b0; sdata = 1'b0;
    mode_pin = pin; cfg_mode = cfg; cfg_wlen = wl;
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    exp_rd = exp_wr;
  endtask

  task automatic run_stream(input string tag, input int fm, input logic [1:0] pin,
                            input logic [1:0] cfg, input logic [1:0] wl, input int nfr);
    int skip, wbits, mx;
    skip  = (fm == 3) ? 0 : 1;
    wbits = (wl == 2'b01) ? 20 : (wl == 2'b10) ? 16 : 24;
    mx    = (fm == 2) ? 32 : 31;
    do_reset(pin, cfg, wl);
    cur_req = tag;
    for (int k = 0; k < nfr; k++) begin
      logic [31:0] lw, rw;
      int ln, rn;
      if (fm == 0) begin ln = wbits; rn = wbits; end
      else begin ln = 1 + int'($urandom % mx); rn = 1 + int'($urandom % mx); end
      if (k == 2) begin ln = (fm == 0) ? wbits : 24; lw = 32'd1 << (ln - 1); end
      else lw = $urandom & msk(ln);
      rw = $urandom & msk(rn);
      if (k >= skip && k <= nfr - 2) push(exp_word(lw, ln), exp_word(rw, rn));
      send_half(fm, lw, ln, 1'b0);
      send_half(fm, rw, rn, 1'b1);
    end
    repeat (20) @(posedge clk);
    chk({tag, " R7 pair count"}, exp_rd, exp_wr);
  endtask

  initial begin
    logic [31:0] lw_a [0:7];
    logic [31:0] rw_a [0:7];
    void'($urandom(32'd7781));
    do_reset(2'b00, 2'b00, 2'b00);
    chk("R10 out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R10 zero_left after reset", {31'd0, zero_left}, 32'd0);
    chk("R10 zero_right after reset", {31'd0, zero_right}, 32'd0);

    run_stream("R5 rj24", 0, 2'b00, 2'b00, 2'b00, 7);
    run_stream("R5 rj20", 0, 2'b00, 2'b00, 2'b01, 7);
    run_stream("R5 rj16", 0, 2'b00, 2'b00, 2'b10, 7);
    run_stream("R2 R6 lj via cfg R1", 2, 2'b00, 2'b10, 2'b00, 9);
    run_stream("R3 i2s via pin R1", 1, 2'b01, 2'b00, 2'b00, 9);
    run_stream("R4 dsp via OR R1", 3, 2'b10, 2'b01, 2'b00, 9);

    // R8: back-pressure holds the first pair and drops the next one
    do_reset(2'b00, 2'b00, 2'b00);
    cur_req = "R8 stall";
    out_ready = 1'b0;
    for (int k = 0; k < 6; k++) begin
      lw_a[k] = $urandom & 32'h00FF_FFFF;
      rw_a[k] = $urandom & 32'h00FF_FFFF;
    end
    for (int k = 0; k < 4; k++) begin
      send_half(0, lw_a[k], 24, 1'b0);
      send_half(0, rw_a[k], 24, 1'b1);
    end
    repeat (10) @(negedge clk);
    chk("R8 valid held", {31'd0, out_valid}, 32'd1);
    chk("R8 held left", {8'h00, out_left}, lw_a[1]);
    chk("R8 held right", {8'h00, out_right}, rw_a[1]);
    push(lw_a[1], rw_a[1]);
    push(lw_a[3], rw_a[3]);
    push(lw_a[4], rw_a[4]);
    out_ready = 1'b1;
    repeat (5) @(posedge clk);
    for (int k = 4; k < 6; k++) begin
      send_half(0, lw_a[k], 24, 1'b0);
      send_half(0, rw_a[k], 24, 1'b1);
    end
    repeat (20) @(posedge clk);
    chk("R8 R7 pair count", exp_rd, exp_wr);

    // R9: left silent for several frames, right busy
    do_reset(2'b00, 2'b00, 2'b00);
    cur_req = "R9 silence";
    for (int k = 0; k < 7; k++) begin
      logic [31:0] lw, rw;
      lw = (k == 6) ? 32'h0000_0100 : 32'd0;
      rw = ($urandom & 32'h00FF_FFFF) | 32'd1;
      if (k >= 1 && k <= 5) push(lw, rw);
      send_half(0, lw, 24, 1'b0);
      send_half(0, rw, 24, 1'b1);
      repeat (4) @(negedge clk);
      if (k == 4) chk("R9 zero_left at threshold", {31'd0, zero_left}, 32'd0);
      if (k == 5) begin
        chk("R9 zero_left past threshold", {31'd0, zero_left}, 32'd1);
        chk("R9 zero_right busy channel", {31'd0, zero_right}, 32'd0);
      end
      if (k == 6) chk("R9 zero_left cleared", {31'd0, zero_left}, 32'd0);
    end
    repeat (20) @(posedge clk);
    chk("R9 R7 pair count", exp_rd, exp_wr);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R7 watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule